// File: doc/BRIEF.md
# Ordered Read-Address Command Detector

This block sits beside an asynchronous-style SRAM control bus that has been brought into a clock domain. It watches the read cycles and looks for one exact run of six read addresses. The first five addresses form a shared prefix. The sixth address decides the outcome: one value requests a nonvolatile store and another requests a nonvolatile recall. When a run completes, the block emits a one-clock command pulse to the store/recall sequencer downstream.

A read counts once, on the clock where it begins. A read begins when chip enable or output enable falls while write enable is high. Reads that belong to a partial run still return normal SRAM data. On the sixth read, the block raises a data-output disable flag for as long as that read stays active. A wrong address or a write cycle sends the matcher back to the start.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After a synchronous reset, `store_pls_o`, `recall_pls_o` and `dq_hiz_o` are all low, and the matcher sits at step zero.
- R2: Reads beginning at 0x04E38, 0x0B1C7, 0x083E0, 0x07C1F and 0x0703F, followed by a read beginning at 0x08FC0, raise `store_pls_o` on the clock after the sixth read begins.
- R3: The same five-address prefix followed by a read at 0x04C63 raises `recall_pls_o` on the clock after the sixth read begins.
- R4: A command pulse lasts exactly one clock. The store and recall pulses are never high together.
- R5: A read at an address other than the expected next one sends the matcher back to step zero. If that address is 0x04E38, the matcher resumes at step one.
- R6: A write cycle (chip enable low and write enable low) at any point in a partial run returns the matcher to step zero.
- R7: A read advances the matcher only on the clock where it begins. Holding the read active longer, or changing the address while it stays active, has no effect.
- R8: A read is recognised whether it begins with the falling edge of chip enable (output enable already low) or with the falling edge of output enable (chip enable already low).
- R9: `dq_hiz_o` is high from the clock after a completing sixth read begins until the clock after that read ends. It stays low during the five prefix reads and during any read that completes no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | SRAM address |
| store_pls_o | output | 1 | One-clock nonvolatile store command |
| recall_pls_o | output | 1 | One-clock nonvolatile recall command |
| dq_hiz_o | output | 1 | Disables the data drivers during the completing read |

## Verification
The bench targets a mismatch that lands on the first sequence address, which should restart the run at step one. A design that simply cleared the matcher would miss a valid run that begins right after a stray read. It also holds a read open while changing the address. A design that counted levels instead of read starts would then advance twice or match the wrong address. Writes placed inside a partial run, and a sixth address that matches neither command, check that no stray pulse or output disable appears. A design that cleared the disable flag too early, or never cleared it, would show up in the flag checks taken before and after each read ends.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    localparam int ADDR_W   = 17;
    localparam int SEQ_LEN  = 6;
    localparam int LAST_IDX = SEQ_LEN - 1;
    localparam int STEP_W   = $clog2(SEQ_LEN);

    localparam logic [ADDR_W-1:0] STORE_ADDR = 17'h08FC0;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef struct packed {
        logic strobe;
        logic rd_now;
        logic wr_cyc;
    } bus_evt_t;

    // Expected address at each step; the last entry is the recall tail.
    function automatic logic [ADDR_W-1:0] seq_addr(input int idx);
        case (idx)
            0:       return 17'h04E38;
            1:       return 17'h0B1C7;
            2:       return 17'h083E0;
            3:       return 17'h07C1F;
            4:       return 17'h0703F;
            default: return 17'h04C63;
        endcase
    endfunction

endpackage

// File: rtl/nvcmd_strobe.sv
module nvcmd_strobe
    import nvcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     we_n,
    output bus_evt_t evt
);
    logic rd_now;
    logic rd_prev_q;

    assign rd_now = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) rd_prev_q <= 1'b0;
        else     rd_prev_q <= rd_now;
    end

    always_comb begin
        evt.rd_now = rd_now;
        evt.strobe = rd_now && !rd_prev_q;
        evt.wr_cyc = !ce_n && !we_n;
    end
endmodule

// File: rtl/nvcmd_matcher.sv
module nvcmd_matcher
    import nvcmd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [AW-1:0] addr,
    output cmd_e          cmd
);
    logic [STEP_W-1:0] step_q, step_d;
    logic              hit_first;

    assign hit_first = (addr == AW'(seq_addr(0)));

    always_comb begin
        step_d = step_q;
        cmd    = CMD_NONE;
        if (evt.wr_cyc) begin
            step_d = '0;
        end else if (evt.strobe) begin
            if (step_q == STEP_W'(LAST_IDX)) begin
                if (addr == AW'(STORE_ADDR))
                    cmd = CMD_STORE;
                else if (addr == AW'(seq_addr(LAST_IDX)))
                    cmd = CMD_RECALL;
                if (cmd != CMD_NONE)
                    step_d = '0;
                else
                    step_d = hit_first ? STEP_W'(1) : '0;
            end else if (addr == AW'(seq_addr(int'(step_q)))) begin
                step_d = step_q + STEP_W'(1);
            end else begin
                step_d = hit_first ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end
endmodule

// File: rtl/nvcmd_out.sv
module nvcmd_out
    import nvcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  cmd_e     cmd,
    output logic     store_pls,
    output logic     recall_pls,
    output logic     dq_hiz
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store_pls  <= 1'b0;
            recall_pls <= 1'b0;
            dq_hiz     <= 1'b0;
        end else begin
            store_pls  <= (cmd == CMD_STORE);
            recall_pls <= (cmd == CMD_RECALL);
            dq_hiz     <= evt.rd_now && (dq_hiz || cmd != CMD_NONE);
        end
    end
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_pls_o,
    output logic              recall_pls_o,
    output logic              dq_hiz_o
);
    bus_evt_t evt;
    cmd_e     cmd;

    nvcmd_strobe u_strobe (
        .clk (clk), .rst (rst), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .evt (evt)
    );

    nvcmd_matcher #(.AW(ADDR_W)) u_match (
        .clk (clk), .rst (rst), .evt (evt), .addr (addr), .cmd (cmd)
    );

    nvcmd_out u_out (
        .clk (clk), .rst (rst), .evt (evt), .cmd (cmd),
        .store_pls (store_pls_o), .recall_pls (recall_pls_o), .dq_hiz (dq_hiz_o)
    );
endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk
    import nvcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              store_pls_o,
    input logic              recall_pls_o,
    input logic              dq_hiz_o
);
    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        !(store_pls_o && recall_pls_o));

    assert_store_width_R4: assert property (@(posedge clk) disable iff (rst)
        store_pls_o |=> !store_pls_o);

    assert_recall_width_R4: assert property (@(posedge clk) disable iff (rst)
        recall_pls_o |=> !recall_pls_o);

    assert_store_addr_R2: assert property (@(posedge clk) disable iff (rst)
        store_pls_o |-> $past(!ce_n && !oe_n && we_n && addr == STORE_ADDR));

    assert_recall_addr_R3: assert property (@(posedge clk) disable iff (rst)
        recall_pls_o |-> $past(!ce_n && !oe_n && we_n && addr == seq_addr(LAST_IDX)));

    assert_hiz_with_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (store_pls_o || recall_pls_o) |-> dq_hiz_o);

    assert_hiz_release_R9: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n || oe_n || !we_n) |-> !dq_hiz_o);

    assert_hiz_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_hiz_o) |-> (store_pls_o || recall_pls_o));
endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk u_chk (
    .clk (clk), .rst (rst), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .addr (addr), .store_pls_o (store_pls_o), .recall_pls_o (recall_pls_o),
    .dq_hiz_o (dq_hiz_o)
);

// File: tb/nvcmd_seq_detect_tb_top.sv
module nvcmd_seq_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic        store_pls_o, recall_pls_o, dq_hiz_o;

    int checks = 0;
    int errors = 0;
    int mstep  = 0;

    localparam logic [16:0] A_STORE = 17'h08FC0;

    always #5 clk = ~clk;

    nvcmd_seq_detect dut_i (
        .clk (clk), .rst (rst), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .addr (addr), .store_pls_o (store_pls_o), .recall_pls_o (recall_pls_o),
        .dq_hiz_o (dq_hiz_o)
    );

    function automatic logic [16:0] ref_addr(input int i);
        case (i)
            0: return 17'h04E38;
            1: return 17'h0B1C7;
            2: return 17'h083E0;
            3: return 17'h07C1F;
            4: return 17'h0703F;
            default: return 17'h04C63;
        endcase
    endfunction

    // Reference model: returns 1 store, 2 recall, 0 none; advances mstep.
    function automatic int model_read(input logic [16:0] a);
        int res = 0;
        if (mstep == 5) begin
            if (a == A_STORE) res = 1;
            else if (a == ref_addr(5)) res = 2;
            mstep = (res != 0) ? 0 : ((a == ref_addr(0)) ? 1 : 0);
        end else if (a == ref_addr(mstep)) begin
            mstep = mstep + 1;
        end else begin
            mstep = (a == ref_addr(0)) ? 1 : 0;
        end
        return res;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    // Read beginning at a; mode 0: chip-enable edge, mode 1: output-enable edge.
    // When a2_valid, the address changes to a2 while the read stays active.
    task automatic do_read(input logic [16:0] a, input int mode,
                           input bit a2_valid, input logic [16:0] a2, input string req);
        int exp_cmd;
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        exp_cmd = model_read(a);
        @(negedge clk);
        check({req, " R2 store pulse"},  store_pls_o,  exp_cmd == 1);
        check({req, " R3 recall pulse"}, recall_pls_o, exp_cmd == 2);
        check({req, " R9 hiz during read"}, dq_hiz_o, exp_cmd != 0);
        if (a2_valid) addr = a2;
        @(negedge clk);
        check({req, " R4 pulse width"}, store_pls_o | recall_pls_o, 1'b0);
        check({req, " R9 hiz held"}, dq_hiz_o, exp_cmd != 0);
        if (mode == 0) ce_n = 1'b1; else oe_n = 1'b1;
        @(negedge clk);
        check({req, " R9 hiz released"}, dq_hiz_o, 1'b0);
    endtask

    task automatic do_write(input logic [16:0] a);
        @(negedge clk);
        addr = a; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        mstep = 0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        check("R6 no output on write", store_pls_o | recall_pls_o | dq_hiz_o, 1'b0);
    endtask

    task automatic prefix(input int mode, input string req);
        for (int i = 0; i < 5; i++) do_read(ref_addr(i), mode, 1'b0, '0, req);
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [16:0] ra;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 store low after reset",  store_pls_o,  1'b0);
        check("R1 recall low after reset", recall_pls_o, 1'b0);
        check("R1 hiz low after reset",    dq_hiz_o,     1'b0);
        rst = 1'b0;

        prefix(0, "R2 R8 ce");  do_read(A_STORE, 0, 1'b0, '0, "R2");
        prefix(1, "R3 R8 oe");  do_read(ref_addr(5), 1, 1'b0, '0, "R3");
        // wrong address mid-run, then restart on first address
        do_read(ref_addr(0), 0, 1'b0, '0, "R5");
        do_read(ref_addr(1), 0, 1'b0, '0, "R5");
        do_read(ref_addr(0), 0, 1'b0, '0, "R5 restart");
        for (int i = 1; i < 5; i++) do_read(ref_addr(i), 0, 1'b0, '0, "R5");
        do_read(A_STORE, 0, 1'b0, '0, "R5 after restart");
        // write inside a partial run
        prefix(0, "R6"); do_write(17'h00123);
        do_read(A_STORE, 0, 1'b0, '0, "R6 no store after write");
        // held read with address change
        do_read(ref_addr(0), 1, 1'b1, ref_addr(1), "R7");
        do_read(ref_addr(1), 1, 1'b1, 17'h1FFFF, "R7");
        for (int i = 2; i < 5; i++) do_read(ref_addr(i), 1, 1'b0, '0, "R7");
        do_read(ref_addr(5), 1, 1'b1, A_STORE, "R7 recall");
        // sixth address matches nothing
        prefix(0, "R9"); do_read(17'h00001, 0, 1'b0, '0, "R9 no cmd");

        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            if (r == 0) do_write(17'($urandom));
            else begin
                if (r < 7) ra = ref_addr(mstep < 5 ? mstep : 0);
                else if (r == 7) ra = ($urandom_range(0, 1) != 0) ? A_STORE : ref_addr(5);
                else ra = ($urandom_range(0, 1) != 0) ? ref_addr($urandom_range(0, 5)) : 17'($urandom);
                if (mstep == 5 && r < 7) ra = ($urandom_range(0, 1) != 0) ? A_STORE : ref_addr(5);
                do_read(ra, int'($urandom_range(0, 1)), 1'b0, '0, "R5 random");
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule